// File: doc/BRIEF.md
# Shared Tick Timer with Per-Core Compare

This block gives every core of a multicore cluster a common timebase and its own timer interrupt. One 32-bit tick count is shared by all cores, so every core reads the same time. The count steps at a fixed tick rate, by default 20 MHz, made by dividing the system clock by `TICK_DIV`. Each core owns a control register that holds an operating mode, an interrupt enable, an interrupt-pending flag and a 28-bit compare value. The compare value is checked against the low 28 bits of the shared count.

When the count reaches a core's compare value, that core's mode sets what happens next. A disabled core ignores the match. A restart-mode core clears the shared count for every core. A one-shot core halts the count. A continuous core lets it run on. Each core accesses the block through its own write strobes and read buses. The block raises a level interrupt per core that stays high until software clears the pending flag.

Top module: `shared_tick_timer`

## Requirements
- R1: After a synchronous active-low reset, every control register, the shared count and every interrupt output read zero.
- R2: While counting is enabled, the shared count rises by exactly one every `TICK_DIV` clock cycles. A count write restarts the tick phase, so the first step after a write lands `TICK_DIV` cycles after the write edge.
- R3: A count write from any core sets the shared value, and all cores' count read buses show it on the next cycle. When several cores write in the same cycle, the lowest-numbered core wins. A count write overrides any step or restart in that cycle.
- R4: The control register fields are mode in bits 31:30 (00 disabled, 01 restart, 10 one-shot, 11 continuous), interrupt enable in bit 29, pending flag in bit 28 and compare value in bits 27:0. Mode, enable and compare value read back as written.
- R5: A match happens on the step where the low 28 bits of the count become equal to the compare value. When the compare value is not above the current low bits, the match waits until those bits wrap through zero.
- R6: A match on a restart-mode core sets the shared count to zero in place of the step.
- R7: A match on a one-shot core stops the count, which then holds its value. A later control write with a non-disabled mode starts it again.
- R8: A match on a continuous-mode core leaves the count running past the compare value.
- R9: A disabled core never sets its pending flag and never acts on the count, even when the count passes its compare value.
- R10: A match sets the core's pending flag only when its enable bit is set. Each interrupt output equals that core's pending flag.
- R11: Writing 0 to bit 28 clears the pending flag. Writing 1 leaves it as it was.
- R12: The count does not advance until some core writes a non-disabled mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | NUM_CORES | Per-core control register write strobe |
| cnt_we | input | NUM_CORES | Per-core shared count write strobe |
| wdata | input | NUM_CORES*32 | Per-core write data, core i in bits 32*i+31:32*i |
| ctl_rdata | output | NUM_CORES*32 | Per-core control register contents |
| cnt_rdata | output | NUM_CORES*32 | Shared count as seen by each core |
| irq | output | NUM_CORES | Per-core timer interrupt (pending flag) |

## Verification
Every register write is captured on one clock edge, and both read buses show the new state right after that edge. A count written at edge 0 with counting enabled therefore reads the written value plus k after edge k·`TICK_DIV`. A match that lands on the step at edge k·`TICK_DIV` shows on the interrupt output and in the count (cleared, frozen or advanced) after that same edge. Every scenario writes the control registers first and the count last, so the count write fixes the tick phase. The bench then waits a whole number of tick periods, sampling on the falling edge. It places samples one tick before and at each expected match, so an early or late match shows up as a wrong value.

// File: rtl/stt_pkg.sv
// Package: shared types and field layout for the shared tick timer.
// Assumes a 32-bit register word on every port.
package stt_pkg;
    localparam int REG_W    = 32;
    localparam int CMP_W    = 28;
    localparam int MODE_LSB = 30;
    localparam int IE_BIT   = 29;
    localparam int PEND_BIT = 28;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_RESTART = 2'b01,
        MODE_ONESHOT = 2'b10,
        MODE_CONT    = 2'b11
    } tmode_e;
endpackage

// File: rtl/stt_tick_gen.sv
// Tick prescaler: pulses tick_o for one cycle every TICK_DIV clocks.
// Assumes clr_i restarts the phase so the next pulse is TICK_DIV-1 cycles
// after the clearing edge (a step lands TICK_DIV edges after it).
module stt_tick_gen #(
    parameter int TICK_DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(TICK_DIV - 1);

    logic [DIV_W-1:0] div_q;

    // Phase counter wrapping at TICK_DIV-1, restarted by clr_i.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i || div_q == LAST) div_q <= '0;
        else                                  div_q <= div_q + 1'b1;
    end

    assign tick_o = (div_q == LAST);

    // A tick never lasts two cycles when the divider exceeds one.
    assert_tick_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((TICK_DIV > 1) && tick_o) |=> !tick_o);
endmodule

// File: rtl/stt_counter.sv
// Shared count register and run flag.
// Assumes channel match flags are computed from the current count and adv_o.
module stt_counter
    import stt_pkg::*;
#(
    parameter int NUM_CORES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick_i,
    input  logic [NUM_CORES-1:0]       cnt_we_i,
    input  logic [NUM_CORES*REG_W-1:0] wdata_i,
    input  logic                       start_i,
    input  logic                       restart_i,
    input  logic                       oneshot_i,
    output logic                       adv_o,
    output logic [REG_W-1:0]           count_o
);
    logic [REG_W-1:0] count_q, wsel;
    logic             run_q, wr_any;

    // Pick the count write from the lowest-numbered requesting core.
    always_comb begin
        wsel = '0;
        for (int i = NUM_CORES - 1; i >= 0; i--) begin
            if (cnt_we_i[i]) wsel = wdata_i[i*REG_W +: REG_W];
        end
    end

    assign wr_any = |cnt_we_i;
    assign adv_o  = tick_i && run_q;

    // Run flag: set by a non-disabled mode write, cleared by a one-shot match.
    always_ff @(posedge clk) begin
        if (!rst_n)         run_q <= 1'b0;
        else if (start_i)   run_q <= 1'b1;
        else if (oneshot_i) run_q <= 1'b0;
    end

    // Count: write beats restart, restart beats step.
    always_ff @(posedge clk) begin
        if (!rst_n)         count_q <= '0;
        else if (wr_any)    count_q <= wsel;
        else if (adv_o)     count_q <= restart_i ? '0 : count_q + 1'b1;
    end

    assign count_o = count_q;

    // Stopped count holds unless written (R7, R12).
    assert_hold_stopped_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !wr_any) |=> $stable(count_q));
    // A plain step adds exactly one.
    assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_o && !wr_any && !restart_i) |=> count_q == $past(count_q) + 32'd1);
    // A restart match clears the shared count.
    assert_restart_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_i && !wr_any) |=> count_q == '0);
endmodule

// File: rtl/stt_channel.sv
// Per-core compare channel: control register, match detect, pending flag.
// Assumes adv_i marks the cycle in which the shared count steps.
module stt_channel
    import stt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [REG_W-1:0] wdata_i,
    input  logic [REG_W-1:0] count_i,
    input  logic             adv_i,
    output logic             restart_o,
    output logic             oneshot_o,
    output logic             start_o,
    output logic [REG_W-1:0] reg_o,
    output logic             irq_o
);
    tmode_e           mode_q;
    logic             ie_q, pend_q, hit;
    logic [CMP_W-1:0] cmp_q, next_low;

    assign next_low  = count_i[CMP_W-1:0] + 1'b1;
    assign hit       = adv_i && (mode_q != MODE_OFF) && (next_low == cmp_q);
    assign restart_o = hit && (mode_q == MODE_RESTART);
    assign oneshot_o = hit && (mode_q == MODE_ONESHOT);
    assign start_o   = we_i && (wdata_i[REG_W-1:MODE_LSB] != 2'b00);

    // Mode, enable and compare fields follow software writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_OFF;
            ie_q   <= 1'b0;
            cmp_q  <= '0;
        end else if (we_i) begin
            mode_q <= tmode_e'(wdata_i[REG_W-1:MODE_LSB]);
            ie_q   <= wdata_i[IE_BIT];
            cmp_q  <= wdata_i[CMP_W-1:0];
        end
    end

    // Pending: set by an enabled match, cleared by writing zero.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= (pend_q && !(we_i && !wdata_i[PEND_BIT])) || (hit && ie_q);
    end

    assign reg_o = {mode_q, ie_q, pend_q, cmp_q};
    assign irq_o = pend_q;

    // A disabled core never raises its pending flag.
    assert_no_pend_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_OFF && !pend_q) |=> !pend_q);
    // Without enable, no pending flag appears.
    assert_no_pend_noie_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ie_q && !pend_q) |=> !pend_q);
endmodule

// File: rtl/shared_tick_timer.sv
// Top: shared tick count with one compare channel per core.
// Assumes TICK_DIV = system clock / 20 MHz.
module shared_tick_timer
    import stt_pkg::*;
#(
    parameter int NUM_CORES = 2,
    parameter int TICK_DIV  = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CORES-1:0]       ctl_we,
    input  logic [NUM_CORES-1:0]       cnt_we,
    input  logic [NUM_CORES*REG_W-1:0] wdata,
    output logic [NUM_CORES*REG_W-1:0] ctl_rdata,
    output logic [NUM_CORES*REG_W-1:0] cnt_rdata,
    output logic [NUM_CORES-1:0]       irq
);
    logic                 tick, adv;
    logic [REG_W-1:0]     count;
    logic [NUM_CORES-1:0] rst_hit, one_hit, start;

    stt_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr_i(|cnt_we), .tick_o(tick)
    );

    stt_counter #(.NUM_CORES(NUM_CORES)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .cnt_we_i(cnt_we),
        .wdata_i(wdata), .start_i(|start), .restart_i(|rst_hit),
        .oneshot_i(|one_hit), .adv_o(adv), .count_o(count)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        stt_channel u_ch (
            .clk(clk), .rst_n(rst_n), .we_i(ctl_we[c]),
            .wdata_i(wdata[c*REG_W +: REG_W]), .count_i(count), .adv_i(adv),
            .restart_o(rst_hit[c]), .oneshot_o(one_hit[c]), .start_o(start[c]),
            .reg_o(ctl_rdata[c*REG_W +: REG_W]), .irq_o(irq[c])
        );
        assign cnt_rdata[c*REG_W +: REG_W] = count;
    end
endmodule

// File: tb/test_shared_tick_timer.sv
module test_shared_tick_timer;
    localparam int N   = 2;
    localparam int DIV = 5;

    logic           clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0]   ctl_we = '0, cnt_we = '0;
    logic [N*32-1:0] wdata = '0;
    logic [N*32-1:0] ctl_rdata, cnt_rdata;
    logic [N-1:0]   irq;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    shared_tick_timer #(.NUM_CORES(N), .TICK_DIV(DIV)) i_shared_tick_timer (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .cnt_we(cnt_we),
        .wdata(wdata), .ctl_rdata(ctl_rdata), .cnt_rdata(cnt_rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] cnt(int c); return cnt_rdata[c*32 +: 32]; endfunction
    function automatic logic [31:0] ctl(int c); return ctl_rdata[c*32 +: 32]; endfunction

    task automatic wait_e(int n); repeat (n) @(negedge clk); endtask

    task automatic wr_ctl(int c, logic [31:0] v);
        ctl_we[c] = 1'b1; wdata[c*32 +: 32] = v;
        @(negedge clk); ctl_we = '0;
    endtask

    task automatic wr_cnt(int c, logic [31:0] v);
        cnt_we[c] = 1'b1; wdata[c*32 +: 32] = v;
        @(negedge clk); cnt_we = '0;
    endtask

    task automatic t_reset();
        check("R1 ctl0", ctl(0), 0); check("R1 ctl1", ctl(1), 0);
        check("R1 cnt", cnt(0), 0);  check("R1 irq", {30'd0, irq}, 0);
        wr_cnt(0, 32'd5); wait_e(4 * DIV);
        check("R12 no count before mode write", cnt(1), 32'd5);
    endtask

    task automatic t_continuous();
        wr_ctl(1, 32'h0); wr_ctl(0, 32'hE000_000A);
        check("R4 readback", ctl(0), 32'hE000_000A);
        wr_cnt(0, 0); wait_e(9 * DIV);
        check("R2 count after 9 ticks", cnt(0), 32'd9);
        check("R5 no early irq", {31'd0, irq[0]}, 0);
        wait_e(DIV);
        check("R5 match count", cnt(0), 32'd10);
        check("R10 irq on match", {31'd0, irq[0]}, 1);
        check("R4 pending bit 28", ctl(0), 32'hF000_000A);
        check("R9 disabled core1 quiet", {31'd0, irq[1]}, 0);
        wait_e(DIV);
        check("R8 count runs on", cnt(1), 32'd11);
        wr_ctl(0, 32'hE000_000A);
        check("R11 pending cleared", {31'd0, irq[0]}, 0);
        wr_ctl(0, 32'hF000_000A);
        check("R11 writing 1 does not set", ctl(0), 32'hE000_000A);
    endtask

    task automatic t_restart();
        wr_ctl(0, 32'h0); wr_ctl(1, 32'h6000_0004);
        wr_cnt(0, 0); wait_e(4 * DIV);
        check("R6 count zeroed", cnt(0), 0);
        check("R6 irq core1", {31'd0, irq[1]}, 1);
        wait_e(DIV);
        check("R6 runs after restart", cnt(0), 1);
        wait_e(3 * DIV);
        check("R6 second restart", cnt(1), 0);
    endtask

    task automatic t_oneshot();
        wr_ctl(1, 32'h0); wr_ctl(0, 32'hA000_0003);
        wr_cnt(0, 0); wait_e(3 * DIV);
        check("R7 match count", cnt(0), 3);
        check("R7 irq", {31'd0, irq[0]}, 1);
        wait_e(4 * DIV);
        check("R7 stopped", cnt(0), 3);
        wr_ctl(0, 32'hA000_0003); wr_cnt(0, 0); wait_e(DIV);
        check("R7 resumes after mode write", cnt(0), 1);
        check("R11 cleared by rewrite", {31'd0, irq[0]}, 0);
    endtask

    task automatic t_wrap();
        wr_ctl(0, 32'hE000_0002);
        wr_cnt(0, 32'h0FFF_FFFE); wait_e(3 * DIV);
        check("R5 before wrap match", cnt(0), 32'h1000_0001);
        check("R5 no irq yet", {31'd0, irq[0]}, 0);
        wait_e(DIV);
        check("R5 wrap match", {31'd0, irq[0]}, 1);
        check("R5 wrap count", cnt(0), 32'h1000_0002);
    endtask

    task automatic t_noie_disabled();
        wr_ctl(0, 32'hC000_0002); wr_ctl(1, 32'h2000_0003);
        wr_cnt(0, 0); wait_e(4 * DIV);
        check("R10 no pending without enable", ctl(0), 32'hC000_0002);
        check("R9 disabled match ignored", {30'd0, irq}, 0);
        check("R9 no counter action", cnt(0), 4);
    endtask

    task automatic t_shared_write();
        wr_cnt(1, 32'h1234_0000);
        check("R3 core0 sees core1 write", cnt(0), 32'h1234_0000);
        cnt_we = 2'b11; wdata = {32'h200, 32'h100};
        @(negedge clk); cnt_we = '0;
        check("R3 lowest core wins", cnt(1), 32'h100);
    endtask

    initial begin
        wait_e(3); rst_n = 1'b1; @(negedge clk);
        t_reset();
        t_continuous();
        t_restart();
        t_oneshot();
        t_wrap();
        t_noie_disabled();
        t_shared_write();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule